// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits on the sample path of a multi-channel converter, just ahead of output formatting. On every sample-rate enable it either forwards the converter's 10-bit word unchanged or replaces it with a generated test word. A 4-bit mode code selects the test word:

- fixed levels;
- alternating words;
- one of two pseudo-random sequences;
- a few fixed serial-friendly shapes;
- user-programmed words, sequenced by a 2-bit field.

The result is registered once and presented with a valid flag that marks each enabled sample.

Both pseudo-random generators run on every enabled sample, whatever the selected mode. A dedicated control bit returns each one to its seed. The alternating patterns and the user sequencing count samples from the moment the mode code or the user field last changed, so a fresh selection always starts at the beginning of its sequence.

Top module: `adc_tpg`

## Requirements
- R1: While `rst` is high and after its release, before any enabled sample, `out_data` is 0x000 and `out_valid` is 0.
- R2: Mode codes 0x0, 0xD, 0xE and 0xF forward `norm_data`. Every other code replaces `norm_data` with its test word, and `norm_data` then has no effect on `out_data`.
- R3: Code 0x1 gives 0x200, code 0x2 gives 0x3FF and code 0x3 gives 0x000 on every sample.
- R4: Code 0x4 gives 0x2AA on the first sample after the pair {mode code, user field} changes, then alternates 0x155, 0x2AA and so on. Any change of the pair restarts this sample index.
- R5: Code 0x7 gives 0x3FF on the first sample of the selection, then alternates 0x000, 0x3FF and so on.
- R6: Code 0x6 outputs the 9-bit short generator zero-extended to 10 bits. The generator is seeded with all ones and steps by shifting left. The new LSB is bit 8 XOR bit 4 (x^9+x^5+1).
- R7: Code 0x5 outputs the low 10 bits of the 23-bit long generator. The generator is seeded with all ones and steps by shifting left. The new LSB is bit 22 XOR bit 17 (x^23+x^18+1).
- R8: Both generators advance exactly once per enabled sample, independent of the selected mode, and hold while `smp_en` is low.
- R9: While `pn_long_clr` is high, the long generator is reloaded with its seed on every clock. `pn_short_clr` does the same for the short generator. Each bit leaves the other generator untouched.
- R10: Code 0x9 gives 0x2AA, code 0xA gives 0x3E0, code 0xB gives 0x001 and code 0xC gives 0x2CE on every sample.
- R11: With code 0x8, user field 00 outputs the live `user_word0` on every sample. User field 01 alternates `user_word0` and `user_word1`, starting with `user_word0`.
- R12: With code 0x8, user field 10 outputs `user_word0` once and then repeats that captured value. User field 11 outputs `user_word0`, then `user_word1`, then repeats the captured `user_word1`. Later changes to the user words do not affect the repeated value until the selection changes.
- R13: `out_valid` is high for exactly the cycle after each enabled sample. `out_data` changes only after an enabled sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample-rate enable, one pulse per sample |
| norm_data | input | 10 | Converter sample to forward in normal mode |
| mode_code | input | 4 | Pattern select code |
| user_ctl | input | 2 | User-word sequencing field |
| pn_long_clr | input | 1 | Hold long generator at seed |
| pn_short_clr | input | 1 | Hold short generator at seed |
| user_word0 | input | 10 | First user pattern word |
| user_word1 | input | 10 | Second user pattern word |
| out_data | output | 10 | Output word, normal or test |
| out_valid | output | 1 | Marks the cycle after an enabled sample |

## Verification
Every result of an enabled sample appears on `out_data` and `out_valid` one clock after the edge that sees `smp_en` high. There is one output register and no other latency. A clear bit reloads its generator one edge after the bit is sampled high. The bench raises `smp_en` at a falling edge and reads the outputs 1 ns after the next rising edge. It drops `smp_en` at the following falling edge, so each read shows exactly one sample. The bench keeps its own models of both generators and advances them once per issued sample, so the expected pseudo-random words stay aligned across tasks. Idle checks read the outputs several cycles after the last enabled sample.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int WORD_W = 10;
    localparam int MODE_W = 4;
    localparam int UCTL_W = 2;
    localparam int CFG_W  = MODE_W + UCTL_W;

    typedef logic [WORD_W-1:0] word_t;

    // Pattern select codes
    localparam logic [MODE_W-1:0] MD_NORMAL   = 4'h0;
    localparam logic [MODE_W-1:0] MD_MID      = 4'h1;
    localparam logic [MODE_W-1:0] MD_POS_FS   = 4'h2;
    localparam logic [MODE_W-1:0] MD_NEG_FS   = 4'h3;
    localparam logic [MODE_W-1:0] MD_CHECKER  = 4'h4;
    localparam logic [MODE_W-1:0] MD_PN_LONG  = 4'h5;
    localparam logic [MODE_W-1:0] MD_PN_SHORT = 4'h6;
    localparam logic [MODE_W-1:0] MD_WORD_TOG = 4'h7;
    localparam logic [MODE_W-1:0] MD_USER     = 4'h8;
    localparam logic [MODE_W-1:0] MD_BIT_TOG  = 4'h9;
    localparam logic [MODE_W-1:0] MD_SYNC     = 4'hA;
    localparam logic [MODE_W-1:0] MD_ONE_HIGH = 4'hB;
    localparam logic [MODE_W-1:0] MD_MIXED    = 4'hC;

    // Fixed words
    localparam word_t W_MID      = 10'h200;
    localparam word_t W_POS_FS   = 10'h3FF;
    localparam word_t W_NEG_FS   = 10'h000;
    localparam word_t W_CHK_EVEN = 10'h2AA;
    localparam word_t W_CHK_ODD  = 10'h155;
    localparam word_t W_BIT_TOG  = 10'h2AA;
    localparam word_t W_SYNC     = 10'h3E0;
    localparam word_t W_ONE_HIGH = 10'h001;
    localparam word_t W_MIXED    = 10'h2CE;

    typedef enum logic [UCTL_W-1:0] {
        US_STEADY = 2'b00,
        US_ALT    = 2'b01,
        US_ONCE1  = 2'b10,
        US_ONCE2  = 2'b11
    } useq_e;

    // Position inside the current selection
    typedef struct packed {
        logic       first;  // sample index is zero
        logic       par;    // parity of sample index
        logic [1:0] cnt;    // sample index, saturating at 3
    } seq_pos_t;

    function automatic word_t alt_word(input logic odd, input word_t even_w,
                                       input word_t odd_w);
        return odd ? odd_w : even_w;
    endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr
    import tpg_pkg::*;
#(
    parameter int LEN  = 9,
    parameter int TAP  = 5,
    parameter int OUTW = WORD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            step,
    output logic [OUTW-1:0] word
);

    localparam logic [LEN-1:0] SEED = '1;

    logic [LEN-1:0] st_q;
    logic           fb;

    assign fb = st_q[LEN-1] ^ st_q[TAP-1];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q <= SEED;
        end else if (step) begin
            st_q <= {st_q[LEN-2:0], fb};
        end
    end

    generate
        if (LEN >= OUTW) begin : g_trunc
            assign word = st_q[OUTW-1:0];
        end else begin : g_zext
            assign word = {{(OUTW-LEN){1'b0}}, st_q};
        end
    endgenerate

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);                                                 // R6
    AST_CLR_RESEEDS: assert property (@(posedge clk) disable iff (rst)
        clr |=> st_q == SEED);                                       // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!step && !clr) |=> $stable(st_q));                          // R8

endmodule

// File: rtl/tpg_seq_track.sv
module tpg_seq_track
    import tpg_pkg::*;
#(
    parameter int CFGW = CFG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [CFGW-1:0] cfg,
    output seq_pos_t        pos
);

    logic [CFGW-1:0] cfg_q;
    logic            vld_q;
    logic            par_q;
    logic [1:0]      cnt_q;

    always_comb begin
        pos.first = !vld_q || (cfg != cfg_q);
        pos.par   = pos.first ? 1'b0 : par_q;
        pos.cnt   = pos.first ? 2'd0 : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cfg_q <= '0;
            par_q <= 1'b0;
            cnt_q <= 2'd0;
        end else if (en) begin
            vld_q <= 1'b1;
            cfg_q <= cfg;
            par_q <= ~pos.par;
            cnt_q <= (pos.cnt == 2'd3) ? 2'd3 : pos.cnt + 2'd1;
        end
    end

    AST_RESTART_INDEX: assert property (@(posedge clk) disable iff (rst)
        (en && pos.first) |=> (cnt_q == 2'd1) && par_q);             // R4
    AST_PARITY_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (en && !pos.first) |=> par_q != $past(par_q));                // R4

endmodule

// File: rtl/tpg_user_seq.sv
module tpg_user_seq
    import tpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     active,
    input  useq_e    ctl,
    input  seq_pos_t pos,
    input  word_t    w0,
    input  word_t    w1,
    output word_t    word
);

    word_t hold_q;
    logic  live;

    always_comb begin
        live = 1'b1;
        word = w0;
        unique case (ctl)
            US_STEADY: word = w0;
            US_ALT:    word = alt_word(pos.par, w0, w1);
            US_ONCE1: begin
                live = (pos.cnt == 2'd0);
                word = live ? w0 : hold_q;
            end
            US_ONCE2: begin
                live = (pos.cnt <= 2'd1);
                word = (pos.cnt == 2'd0) ? w0 : (live ? w1 : hold_q);
            end
            default: word = w0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (en && active && live) begin
            hold_q <= word;
        end
    end

    AST_ONCE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (en && active && (ctl == US_ONCE1) && (pos.cnt != 2'd0))
        |=> $stable(hold_q));                                        // R12

endmodule

// File: rtl/adc_tpg.sv
module adc_tpg
    import tpg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        smp_en,
    input  logic [9:0]  norm_data,
    input  logic [3:0]  mode_code,
    input  logic [1:0]  user_ctl,
    input  logic        pn_long_clr,
    input  logic        pn_short_clr,
    input  logic [9:0]  user_word0,
    input  logic [9:0]  user_word1,
    output logic [9:0]  out_data,
    output logic        out_valid
);

    seq_pos_t pos;
    word_t    pn_long_w;
    word_t    pn_short_w;
    word_t    user_w;
    word_t    sel_w;
    useq_e    uctl;

    assign uctl = useq_e'(user_ctl);

    tpg_seq_track #(.CFGW(CFG_W)) u_track (
        .clk (clk),
        .rst (rst),
        .en  (smp_en),
        .cfg ({mode_code, user_ctl}),
        .pos (pos)
    );

    tpg_lfsr #(.LEN(23), .TAP(18), .OUTW(WORD_W)) u_pn_long (
        .clk  (clk),
        .rst  (rst),
        .clr  (pn_long_clr),
        .step (smp_en),
        .word (pn_long_w)
    );

    tpg_lfsr #(.LEN(9), .TAP(5), .OUTW(WORD_W)) u_pn_short (
        .clk  (clk),
        .rst  (rst),
        .clr  (pn_short_clr),
        .step (smp_en),
        .word (pn_short_w)
    );

    tpg_user_seq u_user (
        .clk    (clk),
        .rst    (rst),
        .en     (smp_en),
        .active (mode_code == MD_USER),
        .ctl    (uctl),
        .pos    (pos),
        .w0     (user_word0),
        .w1     (user_word1),
        .word   (user_w)
    );

    always_comb begin
        case (mode_code)
            MD_MID:      sel_w = W_MID;
            MD_POS_FS:   sel_w = W_POS_FS;
            MD_NEG_FS:   sel_w = W_NEG_FS;
            MD_CHECKER:  sel_w = alt_word(pos.par, W_CHK_EVEN, W_CHK_ODD);
            MD_PN_LONG:  sel_w = pn_long_w;
            MD_PN_SHORT: sel_w = pn_short_w;
            MD_WORD_TOG: sel_w = alt_word(pos.par, W_POS_FS, W_NEG_FS);
            MD_USER:     sel_w = user_w;
            MD_BIT_TOG:  sel_w = W_BIT_TOG;
            MD_SYNC:     sel_w = W_SYNC;
            MD_ONE_HIGH: sel_w = W_ONE_HIGH;
            MD_MIXED:    sel_w = W_MIXED;
            default:     sel_w = norm_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= smp_en;
            if (smp_en) begin
                out_data <= sel_w;
            end
        end
    end

    AST_PASS_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (smp_en && mode_code == MD_NORMAL) |=> out_data == $past(norm_data)); // R2
    AST_MIDSCALE: assert property (@(posedge clk) disable iff (rst)
        (smp_en && mode_code == MD_MID) |=> out_data == 10'h200);             // R3
    AST_WORD_TOG_RAILS: assert property (@(posedge clk) disable iff (rst)
        (smp_en && mode_code == MD_WORD_TOG)
        |=> (out_data == 10'h3FF) || (out_data == 10'h000));                  // R5
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !smp_en |=> $stable(out_data) && !out_valid);                         // R13

endmodule

// File: tb/adc_tpg_tb.sv
`timescale 1ns/1ps
module adc_tpg_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       smp_en;
    logic [9:0] norm_data;
    logic [3:0] mode_code;
    logic [1:0] user_ctl;
    logic       pn_long_clr;
    logic       pn_short_clr;
    logic [9:0] user_word0;
    logic [9:0] user_word1;
    logic [9:0] out_data;
    logic       out_valid;

    int n_chk  = 0;
    int n_fail = 0;
    logic [8:0]  m9;
    logic [22:0] m23;

    always #2 clk = ~clk;

    adc_tpg u_dut (
        .clk(clk), .rst(rst), .smp_en(smp_en), .norm_data(norm_data),
        .mode_code(mode_code), .user_ctl(user_ctl),
        .pn_long_clr(pn_long_clr), .pn_short_clr(pn_short_clr),
        .user_word0(user_word0), .user_word1(user_word1),
        .out_data(out_data), .out_valid(out_valid)
    );

    function automatic logic [8:0] nx9(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4]};
    endfunction
    function automatic logic [22:0] nx23(input logic [22:0] s);
        return {s[21:0], s[22] ^ s[17]};
    endfunction

    task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%03h expected 0x%03h", req, got, exp);
        end
    endtask

    // One enabled sample; returns output seen after the edge
    task automatic sample(output logic [9:0] d);
        @(negedge clk);
        smp_en = 1'b1;
        @(posedge clk);
        #1;
        d = out_data;
        chk("R13 valid", {9'd0, out_valid}, 10'd1);
        m9  = nx9(m9);
        m23 = nx23(m23);
        @(negedge clk);
        smp_en = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] m, input logic [1:0] u);
        @(negedge clk);
        mode_code = m;
        user_ctl  = u;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 data", out_data, 10'h000);
        chk("R1 valid", {9'd0, out_valid}, 10'd0);
        @(negedge clk);
        rst = 1'b0;
        m9 = '1;
        m23 = '1;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 data after release", out_data, 10'h000);
        chk("R1 valid after release", {9'd0, out_valid}, 10'd0);
    endtask

    task automatic t_pass;
        logic [9:0] d;
        set_mode(4'h0, 2'b00);
        norm_data = 10'h1C3;
        sample(d);
        chk("R2 pass", d, 10'h1C3);
        norm_data = 10'h02F;
        sample(d);
        chk("R2 pass", d, 10'h02F);
        for (int c = 13; c < 16; c++) begin
            set_mode(4'(c), 2'b00);
            norm_data = 10'(c * 37);
            sample(d);
            chk("R2 upper codes pass", d, 10'(c * 37));
        end
        set_mode(4'h2, 2'b00);
        norm_data = 10'h055;
        sample(d);
        chk("R2 norm ignored", d, 10'h3FF);
    endtask

    task automatic t_fixed;
        logic [9:0] d;
        set_mode(4'h1, 2'b00); sample(d); chk("R3 mid", d, 10'h200);
        set_mode(4'h2, 2'b00); sample(d); chk("R3 +fs", d, 10'h3FF);
        set_mode(4'h3, 2'b00); sample(d); chk("R3 -fs", d, 10'h000);
        sample(d); chk("R3 -fs repeat", d, 10'h000);
    endtask

    task automatic t_r10_fixed;
        logic [9:0] d;
        set_mode(4'h9, 2'b00); sample(d); chk("R10 bit toggle", d, 10'h2AA);
        sample(d); chk("R10 bit toggle repeat", d, 10'h2AA);
        set_mode(4'hA, 2'b00); sample(d); chk("R10 sync", d, 10'h3E0);
        set_mode(4'hB, 2'b00); sample(d); chk("R10 one high", d, 10'h001);
        set_mode(4'hC, 2'b00); sample(d); chk("R10 mixed", d, 10'h2CE);
    endtask

    task automatic t_checker;
        logic [9:0] d;
        set_mode(4'h4, 2'b00);
        sample(d); chk("R4 chk 0", d, 10'h2AA);
        sample(d); chk("R4 chk 1", d, 10'h155);
        sample(d); chk("R4 chk 2", d, 10'h2AA);
        sample(d); chk("R4 chk 3", d, 10'h155);
        set_mode(4'h0, 2'b00); norm_data = 10'h000; sample(d);
        set_mode(4'h4, 2'b00);
        sample(d); chk("R4 restart on mode", d, 10'h2AA);
        set_mode(4'h4, 2'b01);
        sample(d); chk("R4 restart on user field", d, 10'h2AA);
        sample(d); chk("R4 after restart", d, 10'h155);
    endtask

    task automatic t_word_tog;
        logic [9:0] d;
        set_mode(4'h7, 2'b00);
        sample(d); chk("R5 tog 0", d, 10'h3FF);
        sample(d); chk("R5 tog 1", d, 10'h000);
        sample(d); chk("R5 tog 2", d, 10'h3FF);
    endtask

    task automatic t_pn;
        logic [9:0] d;
        logic [9:0] e;
        set_mode(4'h6, 2'b00);
        for (int i = 0; i < 12; i++) begin
            e = {1'b0, m9};
            sample(d);
            chk("R6 pn short", d, e);
        end
        set_mode(4'h5, 2'b00);
        for (int i = 0; i < 12; i++) begin
            e = m23[9:0];
            sample(d);
            chk("R7 pn long", d, e);
        end
        // generators step while another mode is selected
        set_mode(4'h1, 2'b00);
        for (int i = 0; i < 5; i++) sample(d);
        repeat (4) @(posedge clk);
        set_mode(4'h6, 2'b00);
        e = {1'b0, m9};
        sample(d);
        chk("R8 short stepped in other mode", d, e);
        set_mode(4'h5, 2'b00);
        e = m23[9:0];
        sample(d);
        chk("R8 long stepped in other mode", d, e);
    endtask

    task automatic t_pn_clear;
        logic [9:0] d;
        logic [9:0] e;
        @(negedge clk); pn_short_clr = 1'b1;
        repeat (2) @(negedge clk);
        pn_short_clr = 1'b0;
        m9 = '1;
        set_mode(4'h6, 2'b00);
        sample(d); chk("R9 short reseeded", d, 10'h1FF);
        sample(d); chk("R9 short second", d, 10'h1FE);
        set_mode(4'h5, 2'b00);
        e = m23[9:0];
        sample(d); chk("R9 long untouched by short clear", d, e);
        @(negedge clk); pn_long_clr = 1'b1;
        repeat (2) @(negedge clk);
        pn_long_clr = 1'b0;
        m23 = '1;
        sample(d); chk("R9 long reseeded", d, 10'h3FF);
        sample(d); chk("R9 long second", d, 10'h3FE);
        set_mode(4'h6, 2'b00);
        e = {1'b0, m9};
        sample(d); chk("R9 short untouched by long clear", d, e);
    endtask

    task automatic t_user_r11;
        logic [9:0] d;
        user_word0 = 10'h0A5; user_word1 = 10'h35A;
        set_mode(4'h8, 2'b00);
        sample(d); chk("R11 steady", d, 10'h0A5);
        user_word0 = 10'h111;
        sample(d); chk("R11 steady live", d, 10'h111);
        set_mode(4'h8, 2'b01);
        sample(d); chk("R11 alt 0", d, 10'h111);
        sample(d); chk("R11 alt 1", d, 10'h35A);
        sample(d); chk("R11 alt 2", d, 10'h111);
    endtask

    task automatic t_user_r12;
        logic [9:0] d;
        user_word0 = 10'h123; user_word1 = 10'h321;
        set_mode(4'h8, 2'b10);
        sample(d); chk("R12 once1 first", d, 10'h123);
        user_word0 = 10'h0AB;
        sample(d); chk("R12 once1 held", d, 10'h123);
        sample(d); chk("R12 once1 held again", d, 10'h123);
        user_word0 = 10'h111; user_word1 = 10'h222;
        set_mode(4'h8, 2'b11);
        sample(d); chk("R12 once2 first", d, 10'h111);
        sample(d); chk("R12 once2 second", d, 10'h222);
        user_word1 = 10'h0F0; user_word0 = 10'h00F;
        sample(d); chk("R12 once2 held", d, 10'h222);
        sample(d); chk("R12 once2 held again", d, 10'h222);
    endtask

    task automatic t_idle_r13;
        logic [9:0] d;
        set_mode(4'h0, 2'b00);
        norm_data = 10'h2B7;
        sample(d); chk("R13 sampled", d, 10'h2B7);
        norm_data = 10'h048;
        repeat (3) @(posedge clk);
        #1;
        chk("R13 data held while idle", out_data, 10'h2B7);
        chk("R13 valid low while idle", {9'd0, out_valid}, 10'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; smp_en = 1'b0; norm_data = '0; mode_code = '0;
        user_ctl = '0; pn_long_clr = 1'b0; pn_short_clr = 1'b0;
        user_word0 = '0; user_word1 = '0;
        m9 = '1; m23 = '1;
        t_reset();
        t_pass();
        t_fixed();
        t_r10_fixed();
        t_checker();
        t_word_tog();
        t_pn();
        t_pn_clear();
        t_user_r11();
        t_user_r12();
        t_idle_r13();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule